// File: doc/BRIEF.md
# Three-Operand Signed-Digit Floating-Point Aligner-Adder

This block forms the exact sum X + Y + A of three floating-point operands. Each significand uses a redundant signed-digit form, and each exponent is an unbiased two's-complement integer. It is meant for the inner stage of a fused dot-product-add datapath. There, the product terms arrive in redundant form, and the carry-propagating conversion back to binary is postponed to a later stage. Normalization, rounding, leading-zero detection and that conversion all belong to the stages that follow.

The X and Y exponents are compared by a binary subtraction. The operand with the smaller exponent is shifted right by the difference. The two aligned significands then pass through a carry-limited signed-digit adder. The third operand A takes a separate alignment path that runs alongside this one. A is first placed 30 digits above its own position in a wide field. It is then shifted right by the larger X/Y exponent, minus its own exponent, plus 30, so its shift count is never negative for in-range inputs. A second, wider signed-digit adder adds the aligned A to the intermediate sum. The sign is carried inside the digits, so no sign-handling logic exists.

The block is pipelined over two register stages:
- Stage 1 holds the exponent compare, both alignments and the first addition.
- Stage 2 holds the final wide addition.

Top module: `fp3sd_align_add`

## Requirements
- R1: A result appears on the outputs, with out_valid high, exactly two clock cycles after in_valid is sampled high. out_valid is low in every cycle that does not follow an accepted input by two cycles.
- R2: A synchronous active-low reset drives out_valid, res_pos, res_neg and res_exp to zero on the next clock edge. An operation in flight when reset is applied produces no out_valid.
- R3: Each significand is a pair of 24-bit vectors, pos and neg. Digit i has the value pos[i] - neg[i], and the significand's integer value is the sum over i of digit i times 2^i. An operand's value is that integer times 2^E, where E is its 8-bit two's-complement exponent. A digit with both bits set counts as zero. The result is decoded the same way over 60 digits.
- R4: res_exp is a 9-bit two's-complement number equal to max(E_X, E_Y) - 4. It is the exponent of result digit 0.
- R5: X and Y are each placed 4 digits up in a 28-digit field. The operand with the smaller exponent is then shifted right by |E_X - E_Y|, and digits that pass below digit 0 are dropped. This truncation applies to the pos and neg vectors independently. When the exponents are equal, neither operand is shifted.
- R6: A shift of 28 or more digits on X or Y makes that operand contribute zero.
- R7: A is placed 34 digits up in a 58-digit field and shifted right by max(E_X, E_Y) - E_A + 30. A shift of 58 or more makes A contribute zero. Inputs must keep E_A <= max(E_X, E_Y) + 30.
- R8: The decoded result equals the sum of the decoded aligned X, aligned Y and aligned A, exactly, for any digit patterns.
- R9: Negative and mixed-sign operands need no sign handling. All-zero significands give a result whose pos and neg vectors are both all zero.
- R10: The exponent extremes -128 and 127, in any combination, produce the correct res_exp and alignment, with no wrap in the exponent arithmetic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands on the inputs are to be summed |
| x_pos | input | 24 | X significand, positive-weight bits |
| x_neg | input | 24 | X significand, negative-weight bits |
| x_exp | input | 8 | X exponent, two's complement |
| y_pos | input | 24 | Y significand, positive-weight bits |
| y_neg | input | 24 | Y significand, negative-weight bits |
| y_exp | input | 8 | Y exponent, two's complement |
| a_pos | input | 24 | A significand, positive-weight bits |
| a_neg | input | 24 | A significand, negative-weight bits |
| a_exp | input | 8 | A exponent, two's complement |
| out_valid | output | 1 | Result outputs hold a new sum |
| res_pos | output | 60 | Result significand, positive-weight bits |
| res_neg | output | 60 | Result significand, negative-weight bits |
| res_exp | output | 9 | Exponent of result digit 0, two's complement |

## Verification
A wrong carry or digit-recoding term inside either adder has no local flag. It shows up only as a decoded result value that differs from the exact aligned sum, on the out_valid cycle two clocks after the input. A wrong exponent comparison or shift count shows up in the same cycle, as a result that is off by a power-of-two-scaled portion of one operand, or as a wrong res_exp. The random operands therefore spread their exponents to cover equal exponents, small gaps, the 27/28-digit and 57/58-digit saturation edges, and the widest gaps. Each case is compared with an exact scaled-integer reference.

// File: rtl/fp3sd_pkg.sv
// Package: shared default sizes and a one-bit full adder used by the
// signed-digit adders. Assumes nothing beyond IEEE 1800-2017 semantics.
package fp3sd_pkg;

    localparam int SIG_DIGITS   = 24;  // significand digits per operand
    localparam int EXP_BITS     = 8;   // two's-complement exponent width
    localparam int GUARD_DIGITS = 4;   // digits kept below the X/Y LSB
    localparam int A_PRESHIFT   = 30;  // fixed left placement of A

    // Full adder: returns {carry, sum}.
    function automatic logic [1:0] full_add(input logic a, input logic b, input logic c);
        return {(a & b) | (a & c) | (b & c), a ^ b ^ c};
    endfunction

endpackage

// File: rtl/fp3sd_sd_add.sv
// Carry-limited signed-digit adder.
// Each operand is a pos/neg vector pair, and digit i = pos[i] - neg[i].
// Two rows of full adders work with a constant depth per digit. The first
// row folds b_pos into a. The second row subtracts b_neg, working on the
// negated intermediate. The output is N+2 digits wide, so nothing is lost.
// Assumes nothing about digit patterns: a digit with both bits set is zero.
module fp3sd_sd_add
    import fp3sd_pkg::*;
#(
    parameter int N = 28
) (
    input  logic [N-1:0] a_pos,
    input  logic [N-1:0] a_neg,
    input  logic [N-1:0] b_pos,
    input  logic [N-1:0] b_neg,
    output logic [N+1:0] z_pos,
    output logic [N+1:0] z_neg
);

    logic [N-1:0] row1_sum;
    logic [N-1:0] row1_cry;
    logic [N:0]   mid_pos;
    logic [N:0]   mid_neg;
    logic [N:0]   bneg_ext;
    logic [N:0]   row2_sum;
    logic [N:0]   row2_cry;

    // Row 1: a_pos + b_pos + (1 - a_neg) for each digit.
    generate
        for (genvar i = 0; i < N; i++) begin : g_row1
            assign {row1_cry[i], row1_sum[i]} = full_add(a_pos[i], b_pos[i], ~a_neg[i]);
        end
    endgenerate

    // Intermediate digit i = carry from i-1 minus inverted sum; value a + b_pos.
    assign mid_pos  = {row1_cry, 1'b0};
    assign mid_neg  = {1'b0, ~row1_sum};
    assign bneg_ext = {1'b0, b_neg};

    // Row 2: applied to the negated intermediate, adding b_neg.
    generate
        for (genvar i = 0; i <= N; i++) begin : g_row2
            assign {row2_cry[i], row2_sum[i]} = full_add(mid_neg[i], bneg_ext[i], ~mid_pos[i]);
        end
    endgenerate

    // Negate back: value mid - b_neg = a + b.
    assign z_pos = {1'b0, ~row2_sum};
    assign z_neg = {row2_cry, 1'b0};

endmodule

// File: rtl/fp3sd_rshift.sv
// Signed-digit right shifter with saturation.
// The pos and neg vectors are shifted alike. Digits that pass below digit 0
// are dropped, and a count of W or more yields all-zero digits.
// Assumes SHW > $clog2(W), so the count can reach W.
module fp3sd_rshift #(
    parameter int W   = 28,
    parameter int SHW = 9
) (
    input  logic [W-1:0]   in_pos,
    input  logic [W-1:0]   in_neg,
    input  logic [SHW-1:0] amt,
    output logic [W-1:0]   out_pos,
    output logic [W-1:0]   out_neg
);

    localparam int LV = $clog2(W);

    logic [W-1:0] pos_st [0:LV];
    logic [W-1:0] neg_st [0:LV];
    logic         sat;

    assign pos_st[0] = in_pos;
    assign neg_st[0] = in_neg;

    // Logarithmic stages: stage k shifts by 2^k when amt[k] is set.
    generate
        for (genvar k = 0; k < LV; k++) begin : g_lvl
            assign pos_st[k+1] = amt[k] ? (pos_st[k] >> (2 ** k)) : pos_st[k];
            assign neg_st[k+1] = amt[k] ? (neg_st[k] >> (2 ** k)) : neg_st[k];
        end
    endgenerate

    // Saturate: any count at or beyond the field width clears the operand.
    assign sat     = (amt >= SHW'(W));
    assign out_pos = sat ? '0 : pos_st[LV];
    assign out_neg = sat ? '0 : neg_st[LV];

endmodule

// File: rtl/fp3sd_exp_align.sv
// Exponent unit.
// It subtracts E_X - E_Y to find the larger exponent and the X/Y shift. In
// parallel it forms the A shift as E_big - E_A + PRE, and the exponent of
// result digit 0 as E_big - GRD.
// Assumes E_A <= E_big + PRE; a negative A count is clamped to zero.
module fp3sd_exp_align #(
    parameter int EXPW = 8,
    parameter int PRE  = 30,
    parameter int GRD  = 4
) (
    input  logic [EXPW-1:0] e_x,
    input  logic [EXPW-1:0] e_y,
    input  logic [EXPW-1:0] e_a,
    output logic [EXPW:0]   x_shamt,
    output logic [EXPW:0]   y_shamt,
    output logic [EXPW:0]   a_shamt,
    output logic [EXPW:0]   e_res
);

    localparam logic signed [EXPW+1:0] PRE_V = PRE;
    localparam logic        [EXPW:0]   GRD_V = GRD;

    logic signed [EXPW:0]   dxy;
    logic                   x_lt;
    logic        [EXPW:0]   mag;
    logic        [EXPW-1:0] e_big;
    logic signed [EXPW+1:0] oa;

    // X/Y compare: a one-bit-wider subtraction cannot overflow.
    assign dxy  = $signed({e_x[EXPW-1], e_x}) - $signed({e_y[EXPW-1], e_y});
    assign x_lt = dxy[EXPW];
    assign mag  = x_lt ? (EXPW+1)'(-dxy) : dxy;

    // Route the difference to the operand with the smaller exponent.
    assign x_shamt = x_lt ? mag : '0;
    assign y_shamt = x_lt ? '0 : mag;
    assign e_big   = x_lt ? e_y : e_x;

    // A offset, two bits wider than the exponents so it never wraps.
    assign oa = $signed({{2{e_big[EXPW-1]}}, e_big})
              - $signed({{2{e_a[EXPW-1]}}, e_a}) + PRE_V;
    assign a_shamt = oa[EXPW+1] ? '0 : oa[EXPW:0];

    // Exponent of result digit 0.
    assign e_res = {e_big[EXPW-1], e_big} - GRD_V;

endmodule

// File: rtl/fp3sd_align_add.sv
// Top: three-operand signed-digit FP aligner-adder, latency two cycles.
// Stage 1: exponent unit, X/Y alignment and first signed-digit addition,
//          with A alignment running alongside.
// Stage 2: wide signed-digit addition of the aligned A and the first sum.
// Assumes E_A <= max(E_X, E_Y) + PRE. Registers load only on valid.
module fp3sd_align_add
    import fp3sd_pkg::*;
#(
    parameter int SIG  = SIG_DIGITS,
    parameter int EXPW = EXP_BITS,
    parameter int GRD  = GUARD_DIGITS,
    parameter int PRE  = A_PRESHIFT
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [SIG-1:0]            x_pos,
    input  logic [SIG-1:0]            x_neg,
    input  logic [EXPW-1:0]           x_exp,
    input  logic [SIG-1:0]            y_pos,
    input  logic [SIG-1:0]            y_neg,
    input  logic [EXPW-1:0]           y_exp,
    input  logic [SIG-1:0]            a_pos,
    input  logic [SIG-1:0]            a_neg,
    input  logic [EXPW-1:0]           a_exp,
    output logic                      out_valid,
    output logic [SIG+GRD+PRE+1:0]    res_pos,
    output logic [SIG+GRD+PRE+1:0]    res_neg,
    output logic [EXPW:0]             res_exp
);

    localparam int FW   = SIG + GRD;        // X/Y aligned field
    localparam int SUMW = FW + 2;           // first sum width
    localparam int AW   = SIG + GRD + PRE;  // A aligned field
    localparam int RESW = AW + 2;           // final sum width
    localparam int SHW  = EXPW + 1;         // shift count width

    logic [SHW-1:0]  x_sh, y_sh, a_sh;
    logic [EXPW:0]   e_res;
    logic [FW-1:0]   xal_pos, xal_neg, yal_pos, yal_neg;
    logic [SUMW-1:0] sum_pos, sum_neg;
    logic [AW-1:0]   aal_pos, aal_neg;

    logic            s1_valid;
    logic [SUMW-1:0] s1_sum_pos, s1_sum_neg;
    logic [AW-1:0]   s1_a_pos, s1_a_neg;
    logic [EXPW:0]   s1_exp;
    logic [RESW-1:0] fin_pos, fin_neg;

    fp3sd_exp_align #(.EXPW(EXPW), .PRE(PRE), .GRD(GRD)) i_exp (
        .e_x     (x_exp),
        .e_y     (y_exp),
        .e_a     (a_exp),
        .x_shamt (x_sh),
        .y_shamt (y_sh),
        .a_shamt (a_sh),
        .e_res   (e_res)
    );

    fp3sd_rshift #(.W(FW), .SHW(SHW)) i_xsh (
        .in_pos  ({x_pos, {GRD{1'b0}}}),
        .in_neg  ({x_neg, {GRD{1'b0}}}),
        .amt     (x_sh),
        .out_pos (xal_pos),
        .out_neg (xal_neg)
    );

    fp3sd_rshift #(.W(FW), .SHW(SHW)) i_ysh (
        .in_pos  ({y_pos, {GRD{1'b0}}}),
        .in_neg  ({y_neg, {GRD{1'b0}}}),
        .amt     (y_sh),
        .out_pos (yal_pos),
        .out_neg (yal_neg)
    );

    fp3sd_sd_add #(.N(FW)) i_add_xy (
        .a_pos (xal_pos),
        .a_neg (xal_neg),
        .b_pos (yal_pos),
        .b_neg (yal_neg),
        .z_pos (sum_pos),
        .z_neg (sum_neg)
    );

    // A path: placed PRE+GRD digits up, then shifted right by the offset.
    fp3sd_rshift #(.W(AW), .SHW(SHW)) i_ash (
        .in_pos  ({a_pos, {(PRE+GRD){1'b0}}}),
        .in_neg  ({a_neg, {(PRE+GRD){1'b0}}}),
        .amt     (a_sh),
        .out_pos (aal_pos),
        .out_neg (aal_neg)
    );

    // Stage 1 register: the first sum, the aligned A and the result exponent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid   <= 1'b0;
            s1_sum_pos <= '0;
            s1_sum_neg <= '0;
            s1_a_pos   <= '0;
            s1_a_neg   <= '0;
            s1_exp     <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_sum_pos <= sum_pos;
                s1_sum_neg <= sum_neg;
                s1_a_pos   <= aal_pos;
                s1_a_neg   <= aal_neg;
                s1_exp     <= e_res;
            end
        end
    end

    // Final adder: the upper digits of the narrow sum are constant zero.
    fp3sd_sd_add #(.N(AW)) i_add_fin (
        .a_pos (s1_a_pos),
        .a_neg (s1_a_neg),
        .b_pos ({{(AW-SUMW){1'b0}}, s1_sum_pos}),
        .b_neg ({{(AW-SUMW){1'b0}}, s1_sum_neg}),
        .z_pos (fin_pos),
        .z_neg (fin_neg)
    );

    // Stage 2 register: the final result and its exponent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            res_pos   <= '0;
            res_neg   <= '0;
            res_exp   <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                res_pos <= fin_pos;
                res_neg <= fin_neg;
                res_exp <= s1_exp;
            end
        end
    end

endmodule

// File: rtl/fp3sd_align_add_chk.sv
// Checker for fp3sd_align_add: latency, reset, exponent and zero behaviour,
// observed at the ports only. Attached by the bind at the end of this file.
module fp3sd_align_add_chk #(
    parameter int SIG  = 24,
    parameter int EXPW = 8,
    parameter int GRD  = 4,
    parameter int PRE  = 30
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic [SIG-1:0]         x_pos,
    input logic [SIG-1:0]         x_neg,
    input logic [EXPW-1:0]        x_exp,
    input logic [SIG-1:0]         y_pos,
    input logic [SIG-1:0]         y_neg,
    input logic [EXPW-1:0]        y_exp,
    input logic [SIG-1:0]         a_pos,
    input logic [SIG-1:0]         a_neg,
    input logic                   out_valid,
    input logic [SIG+GRD+PRE+1:0] res_pos,
    input logic [SIG+GRD+PRE+1:0] res_neg,
    input logic [EXPW:0]          res_exp
);

    localparam logic [EXPW:0] GRD_V = GRD;

    logic [EXPW:0] exp_want;
    logic          all_zero;

    // Expected exponent from a signed comparison of the two inputs.
    assign exp_want = ($signed(x_exp) >= $signed(y_exp))
                    ? ({x_exp[EXPW-1], x_exp} - GRD_V)
                    : ({y_exp[EXPW-1], y_exp} - GRD_V);
    assign all_zero = (x_pos == '0) && (x_neg == '0) && (y_pos == '0)
                   && (y_neg == '0) && (a_pos == '0) && (a_neg == '0);

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);  // R1

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);  // R1

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && res_pos == '0 && res_neg == '0 && res_exp == '0));  // R2

    AST_EXP_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 (res_exp == $past(exp_want, 2)));  // R4

    AST_ZERO_PROPAGATES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && all_zero) |-> ##2 (res_pos == '0 && res_neg == '0));  // R9

endmodule

bind fp3sd_align_add fp3sd_align_add_chk #(
    .SIG(SIG), .EXPW(EXPW), .GRD(GRD), .PRE(PRE)
) i_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .x_pos(x_pos), .x_neg(x_neg), .x_exp(x_exp),
    .y_pos(y_pos), .y_neg(y_neg), .y_exp(y_exp),
    .a_pos(a_pos), .a_neg(a_neg),
    .out_valid(out_valid), .res_pos(res_pos), .res_neg(res_neg), .res_exp(res_exp)
);

// File: tb/test_fp3sd_align_add.sv
// Bench for fp3sd_align_add. Directed corner cases are followed by seeded
// random operands. Each result is compared with an exact scaled-integer
// reference built from the requirements.
module test_fp3sd_align_add;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [23:0] x_pos = '0, x_neg = '0, y_pos = '0, y_neg = '0, a_pos = '0, a_neg = '0;
    logic [7:0]  x_exp = '0, y_exp = '0, a_exp = '0;
    logic        out_valid;
    logic [59:0] res_pos, res_neg;
    logic [8:0]  res_exp;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    fp3sd_align_add i_fp3sd_align_add (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .x_pos(x_pos), .x_neg(x_neg), .x_exp(x_exp),
        .y_pos(y_pos), .y_neg(y_neg), .y_exp(y_exp),
        .a_pos(a_pos), .a_neg(a_neg), .a_exp(a_exp),
        .out_valid(out_valid), .res_pos(res_pos), .res_neg(res_neg), .res_exp(res_exp)
    );

    function automatic void check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endfunction

    function automatic int sx8(input logic [7:0] e);
        return int'($signed(e));
    endfunction

    // Decoded value of one aligned operand: pos and neg truncated separately.
    function automatic longint aligned(input logic [23:0] p, input logic [23:0] n,
                                       input int up, input int sh);
        logic [63:0] tp, tn;
        tp = ({40'b0, p} << up) >> sh;
        tn = ({40'b0, n} << up) >> sh;
        return longint'(tp) - longint'(tn);
    endfunction

    function automatic longint ref_sum(input logic [23:0] xp, xn, input logic [7:0] ex,
                                       input logic [23:0] yp, yn, input logic [7:0] ey,
                                       input logic [23:0] ap, an, input logic [7:0] ea);
        int big;
        big = (sx8(ex) > sx8(ey)) ? sx8(ex) : sx8(ey);
        return aligned(xp, xn, 4, big - sx8(ex)) + aligned(yp, yn, 4, big - sx8(ey))
             + aligned(ap, an, 34, big - sx8(ea) + 30);
    endfunction

    function automatic longint ref_exp(input logic [7:0] ex, input logic [7:0] ey);
        int big;
        logic [8:0] e9;
        big = (sx8(ex) > sx8(ey)) ? sx8(ex) : sx8(ey);
        e9  = 9'(big - 4);
        return longint'(e9);
    endfunction

    function automatic longint decoded();
        return longint'({4'b0, res_pos}) - longint'({4'b0, res_neg});
    endfunction

    task automatic run(input string req,
                       input logic [23:0] xp, xn, input logic [7:0] ex,
                       input logic [23:0] yp, yn, input logic [7:0] ey,
                       input logic [23:0] ap, an, input logic [7:0] ea);
        @(negedge clk);
        x_pos = xp; x_neg = xn; x_exp = ex;
        y_pos = yp; y_neg = yn; y_exp = ey;
        a_pos = ap; a_neg = an; a_exp = ea;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check({req, " R1 out_valid"}, longint'(out_valid), 1);
        check({req, " value"}, decoded(), ref_sum(xp, xn, ex, yp, yn, ey, ap, an, ea));
        check({req, " R4 exponent"}, longint'(res_exp), ref_exp(ex, ey));
    endtask

    function automatic int clampe(input int v);
        return (v > 127) ? 127 : ((v < -128) ? -128 : v);
    endfunction

    initial begin : watchdog
        #(4 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R2: state held in reset
        check("R2 reset out_valid", longint'(out_valid), 0);
        check("R2 reset res_pos", longint'(res_pos == '0), 1);
        check("R2 reset res_neg", longint'(res_neg == '0), 1);
        check("R2 reset res_exp", longint'(res_exp), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: zero operands and exponents
        run("R9 zero", 24'h0, 24'h0, 8'd5, 24'h0, 24'h0, 8'd250, 24'h0, 24'h0, 8'd3);
        check("R9 zero pos digits", longint'(res_pos == '0), 1);
        check("R9 zero neg digits", longint'(res_neg == '0), 1);
        // R1: no valid the following cycle
        @(negedge clk);
        check("R1 out_valid drops", longint'(out_valid), 0);

        // R3: digits with both bits set count as zero
        run("R3 both bits", 24'hFFFFFF, 24'hFFFFFF, 8'd0, 24'd5, 24'd0, 8'd0, 24'd0, 24'd0, 8'd0);
        check("R3 decoded 80", decoded(), 80);
        // R5: equal exponents, no shift
        run("R5 equal exp", 24'd1, 24'd0, 8'd3, 24'd1, 24'd0, 8'd3, 24'd0, 24'd0, 8'd3);
        check("R5 decoded 32", decoded(), 32);
        // R5: gap of two, Y truncated to 4
        run("R5 gap2", 24'd4, 24'd0, 8'd2, 24'd1, 24'd0, 8'd0, 24'd0, 24'd0, 8'd0);
        check("R5 decoded 68", decoded(), 68);
        // R5: X smaller, negative digits dropped independently
        run("R5 x smaller", 24'd7, 24'd3, 8'hFE, 24'd9, 24'd0, 8'd1, 24'd0, 24'd0, 8'd1);
        // R6: saturation edge at 27 and 28
        run("R6 shift27", 24'h0, 24'h0, 8'd0, 24'hFFFFFF, 24'h0, 8'(-27), 24'h0, 24'h0, 8'd0);
        check("R6 shift27 keeps 1", decoded(), 1);
        run("R6 shift28", 24'h0, 24'h0, 8'd0, 24'hFFFFFF, 24'h0, 8'(-28), 24'h0, 24'h0, 8'd0);
        check("R6 shift28 zero", decoded(), 0);
        // R7: A offsets 0, 30, 57, 58
        run("R7 a top", 24'h0, 24'h0, 8'd10, 24'h0, 24'h0, 8'd4, 24'hFFFFFF, 24'h0, 8'd40);
        run("R7 a level", 24'd3, 24'h0, 8'd10, 24'h0, 24'h0, 8'd4, 24'd5, 24'h0, 8'd10);
        check("R7 a level 128", decoded(), 128);
        run("R7 a shift57", 24'h0, 24'h0, 8'd0, 24'h0, 24'h0, 8'd0, 24'h800000, 24'h0, 8'(-27));
        check("R7 shift57 keeps 1", decoded(), 1);
        run("R7 a shift58", 24'h0, 24'h0, 8'd0, 24'h0, 24'h0, 8'd0, 24'hFFFFFF, 24'h0, 8'(-28));
        check("R7 shift58 zero", decoded(), 0);
        // R9: opposite signs cancel; all-negative sum
        run("R9 cancel", 24'h0, 24'hABCDEF, 8'd7, 24'hABCDEF, 24'h0, 8'd7, 24'h0, 24'h0, 8'd7);
        run("R9 negative", 24'h0, 24'hFFFFFF, 8'd1, 24'h0, 24'hFFFFFF, 8'd1, 24'h0, 24'hFFFFFF, 8'd31);
        // R10: exponent extremes
        run("R10 max min", 24'h123456, 24'h0, 8'd127, 24'hFFFFFF, 24'h0, 8'h80, 24'hFFFFFF, 24'h0, 8'h80);
        run("R10 both min", 24'h1, 24'h2, 8'h80, 24'h3, 24'h0, 8'h80, 24'h4, 24'h0, 8'h80);
        run("R10 y max", 24'h5, 24'h0, 8'h80, 24'h6, 24'h1, 8'd127, 24'hFFF, 24'h0, 8'd127);

        // R2: a reset while an operation is in flight suppresses its result
        @(negedge clk);
        x_pos = 24'd9; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        check("R2 in-flight dropped", longint'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: random digits and exponent spreads
        for (int it = 0; it < 400; it++) begin
            int ex, ey, ea, big, kind, spread;
            ex   = int'($urandom_range(255)) - 128;
            kind = int'($urandom_range(4));
            case (kind)
                0:       spread = 0;
                1:       spread = int'($urandom_range(54)) - 27;
                2:       spread = ($urandom_range(1) != 0) ? 28 : -28;
                3:       spread = ($urandom_range(1) != 0) ? 27 : -27;
                default: spread = int'($urandom_range(510)) - 255;
            endcase
            ey  = clampe(ex + spread);
            big = (ex > ey) ? ex : ey;
            ea  = clampe(big + int'($urandom_range(100)) - 70);
            run("R8 random",
                24'($urandom), 24'($urandom), 8'(ex),
                24'($urandom), 24'($urandom), 8'(ey),
                24'($urandom), 24'($urandom), 8'(ea));
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule